// File: doc/BRIEF.md
# Double-Buffered Six-Channel PWM Generator

This block turns a free-running period counter into six pulse-width modulated outputs. A timer core outside the block supplies the count value and a one-cycle boundary flag that is high in the cycle the count sits at the period value, just before it returns to zero. The block gives the timer core the active period through `period_o`. Seven compare slots feed it. Slot 0 is the period and slots 1 to 6 are edge positions. Software writes each slot into a holding register through a simple write port. The active copy of a slot is taken from its holding register only at a boundary, and only if that slot has been armed. Each arm bit clears itself once its transfer is done.

Each output is a set/reset state bit, and reset wins over set. In single-edge mode, channel n rises at count zero and falls when the count equals slot n. Channels 2 to 6 can instead use double-edge mode. There they rise when the count equals slot n-1 and fall when it equals slot n. This allows three independent double-edge pulses. A per-channel enable forces its output low. The state bit keeps tracking the counter while the output is disabled, so enabling a channel takes effect at once and stays in phase.

Top module: `pwm_shadow_top`

## Requirements
- R1: During and right after reset every output is low, `period_o` is zero, all active slots and arm bits are zero and every channel is disabled.
- R2: A write to address k (0 to 6) loads holding slot k with the low bits of the write data. `period_o` always shows the active copy of slot 0.
- R3: In a cycle with `wrap_i` high, each armed slot copies its holding value into its active copy. Unarmed slots keep their active value, and no active copy changes in any other cycle.
- R4: An arm bit clears in the same boundary that uses it. A later holding write is not applied until the slot is armed again.
- R5: A single-edge channel n is high in every count below active slot n and low from that count to the end of the period. A value of 0 gives low for the whole period. A value above the period gives high for the whole period.
- R6: A double-edge channel n is set when the count equals active slot n-1 and cleared when it equals active slot n. When both match in one cycle it is cleared.
- R7: Writing address 7 sets the control word. Bit n (n = 2 to 6) selects double-edge (1) or single-edge (0) for channel n. Channel 1 is always single-edge, so bit 1 has no effect. Bit 8+n enables output n. A disabled output is low. Enabling or disabling changes the output in the first cycle after the write, in phase with the counter.
- R8: Writing address 8 arms every slot whose bit (bit k for slot k, k = 0 to 6) is 1 in the data. Zero bits leave the existing arm bits alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_i | input | CW | Current period count from the timer core |
| wrap_i | input | 1 | High in the cycle the count equals the period, before it returns to zero |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW | Write address: 0-6 slots, 7 control, 8 arm |
| wr_data_i | input | DW | Write data |
| out_o | output | NCH | PWM outputs, bit 0 is channel 1 |
| period_o | output | CW | Active period value for the timer core |

## Verification
The bench uses the default six channels with a 16-bit count. Most periods are 8 to 12 counts, so one vector with a settling period and a checked period takes only a few dozen cycles. One vector uses a period of 100 with a falling edge at 60, to cover a longer cycle. With these short periods the bench can compare every count of a full period against its own model. That covers zero duty, duty equal to the period and duty above it, coincident double-edge slots, and enables flipped in mid-period.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;

    typedef enum logic {
        EDGE_SINGLE = 1'b0,
        EDGE_DOUBLE = 1'b1
    } edge_mode_e;

    // Write address of the control word for a given channel count
    function automatic int unsigned ctrl_addr(input int unsigned nch);
        return nch + 1;
    endfunction

    // Write address of the arm (load request) word
    function automatic int unsigned arm_addr(input int unsigned nch);
        return nch + 2;
    endfunction

    // Lowest control bit holding an output enable (channel 1)
    function automatic int unsigned en_lo(input int unsigned nch);
        return nch + 3;
    endfunction

endpackage

// File: rtl/pwm_cmp_bank.sv
module pwm_cmp_bank
    import pwm_shadow_pkg::*;
#(
    parameter int NCMP = 7,
    parameter int CW   = 16,
    parameter int AW   = 4,
    parameter int DW   = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wrap_i,
    input  logic                      wr_en_i,
    input  logic [AW-1:0]             wr_addr_i,
    input  logic [DW-1:0]             wr_data_i,
    output logic [NCMP-1:0][CW-1:0]   hold_o,
    output logic [NCMP-1:0][CW-1:0]   shad_o,
    output logic [NCMP-1:0]           arm_o
);

    localparam int ARM_ADDR = arm_addr(NCMP - 1);

    typedef struct packed {
        logic [NCMP-1:0][CW-1:0] hold;
        logic [NCMP-1:0][CW-1:0] shad;
        logic [NCMP-1:0]         arm;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        // boundary transfer of armed slots, then the arm bit drops
        if (wrap_i) begin
            for (int k = 0; k < NCMP; k++) begin
                if (bank_q.arm[k]) begin
                    bank_d.shad[k] = bank_q.hold[k];
                    bank_d.arm[k]  = 1'b0;
                end
            end
        end
        if (wr_en_i) begin
            for (int k = 0; k < NCMP; k++) begin
                if (wr_addr_i == AW'(k)) begin
                    bank_d.hold[k] = wr_data_i[CW-1:0];
                end
            end
            // new arm requests are merged after the clear
            if (wr_addr_i == AW'(ARM_ADDR)) begin
                bank_d.arm = bank_d.arm | wr_data_i[NCMP-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign hold_o = bank_q.hold;
    assign shad_o = bank_q.shad;
    assign arm_o  = bank_q.arm;

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_shadow_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_i,
    input  logic [CW-1:0] lo_cmp_i,
    input  logic [CW-1:0] hi_cmp_i,
    input  edge_mode_e    mode_i,
    input  logic          en_i,
    output logic          out_o
);

    typedef struct packed {
        logic level;
    } chan_t;

    chan_t chan_d, chan_q;
    logic  set_ev, clr_ev, level_now;

    always_comb begin
        chan_d = chan_q;
        if (mode_i == EDGE_DOUBLE) begin
            set_ev = (cnt_i == lo_cmp_i);
        end else begin
            set_ev = (cnt_i == '0);
        end
        clr_ev = (cnt_i == hi_cmp_i);
        // clear has priority over set
        if (clr_ev) begin
            level_now = 1'b0;
        end else if (set_ev) begin
            level_now = 1'b1;
        end else begin
            level_now = chan_q.level;
        end
        // state keeps tracking even while the output is gated
        chan_d.level = level_now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q <= '0;
        end else begin
            chan_q <= chan_d;
        end
    end

    assign out_o = en_i & level_now;

endmodule

// File: rtl/pwm_shadow_top.sv
module pwm_shadow_top
    import pwm_shadow_pkg::*;
#(
    parameter  int NCH    = 6,
    parameter  int CW     = 16,
    localparam int NCMP   = NCH + 1,
    localparam int CTRL_W = 2 * NCH + 3,
    localparam int AW     = $clog2(NCH + 3),
    localparam int DW     = (CW > CTRL_W) ? CW : CTRL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_i,
    input  logic          wrap_i,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [DW-1:0] wr_data_i,
    output logic [NCH-1:0] out_o,
    output logic [CW-1:0] period_o
);

    localparam int CTRL_ADDR = ctrl_addr(NCH);
    localparam int EN_LO     = en_lo(NCH);

    typedef struct packed {
        logic [NCH:2]   dbl;
        logic [NCH-1:0] en;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic [NCMP-1:0][CW-1:0] hold_w;
    logic [NCMP-1:0][CW-1:0] shad_w;
    logic [NCMP-1:0]         arm_w;
    logic [NCH:2]            dbl_q;
    logic [NCH-1:0]          en_q;
    edge_mode_e              mode_w [NCH];

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en_i && wr_addr_i == AW'(CTRL_ADDR)) begin
            ctrl_d.dbl = wr_data_i[NCH:2];
            ctrl_d.en  = wr_data_i[EN_LO+NCH-1:EN_LO];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign dbl_q = ctrl_q.dbl;
    assign en_q  = ctrl_q.en;

    pwm_cmp_bank #(
        .NCMP (NCMP),
        .CW   (CW),
        .AW   (AW),
        .DW   (DW)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wrap_i    (wrap_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .hold_o    (hold_w),
        .shad_o    (shad_w),
        .arm_o     (arm_w)
    );

    assign period_o = shad_w[0];

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        if (g == 0) begin : g_fixed
            assign mode_w[g] = EDGE_SINGLE;
        end else begin : g_sel
            assign mode_w[g] = edge_mode_e'(dbl_q[g+1]);
        end

        pwm_chan #(
            .CW (CW)
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .cnt_i    (cnt_i),
            .lo_cmp_i (shad_w[g]),
            .hi_cmp_i (shad_w[g+1]),
            .mode_i   (mode_w[g]),
            .en_i     (en_q[g]),
            .out_o    (out_o[g])
        );
    end

endmodule

// File: rtl/pwm_shadow_chk.sv
module pwm_shadow_chk #(
    parameter int NCH = 6,
    parameter int CW  = 16,
    parameter int AW  = 4,
    parameter int DW  = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [CW-1:0]            cnt_i,
    input logic                     wrap_i,
    input logic                     wr_en_i,
    input logic [AW-1:0]            wr_addr_i,
    input logic [DW-1:0]            wr_data_i,
    input logic [NCH-1:0]           out_o,
    input logic [CW-1:0]            period_o,
    input logic [NCH:0][CW-1:0]     hold_w,
    input logic [NCH:0][CW-1:0]     shad_w,
    input logic [NCH:0]             arm_w,
    input logic [NCH:2]             dbl_q,
    input logic [NCH-1:0]           en_q
);

    localparam int ARM_ADDR = NCH + 2;

    logic was_rst_q;
    logic arm_wr;

    assign arm_wr = wr_en_i && (wr_addr_i == AW'(ARM_ADDR)) && (wr_data_i != '0);

    always_ff @(posedge clk) begin
        was_rst_q <= !rst_n;
    end

    // first edge after reset release: quiet outputs, zero period
    always @(posedge clk) begin
        if (rst_n && was_rst_q) begin
            assert_reset_quiet_R1: assert (out_o == '0 && period_o == '0);
        end
    end

    assert_period_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_i && arm_w[0]) |=> (period_o == $past(hold_w[0])));

    assert_period_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrap_i) |=> $stable(period_o));

    assert_arm_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_i && !arm_wr) |=> (arm_w == '0));

    assert_single_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q[0] && cnt_i == shad_w[1]) |-> !out_o[0]);

    assert_double_priority_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dbl_q[2] && en_q[1] && cnt_i == shad_w[2]) |-> !out_o[1]);

endmodule

bind pwm_shadow_top pwm_shadow_chk #(
    .NCH (NCH),
    .CW  (CW),
    .AW  (AW),
    .DW  (DW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_i     (cnt_i),
    .wrap_i    (wrap_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .out_o     (out_o),
    .period_o  (period_o),
    .hold_w    (hold_w),
    .shad_w    (shad_w),
    .arm_w     (arm_w),
    .dbl_q     (dbl_q),
    .en_q      (en_q)
);

// File: tb/sim_pwm_shadow_top.sv
module sim_pwm_shadow_top;

    localparam int NCH = 6;
    localparam int CW  = 16;
    localparam int AW  = 4;
    localparam int DW  = 16;
    localparam int WATCHDOG = 150000;

    typedef struct packed {
        logic [15:0] per;
        logic [15:0] d1, d2, d3, d4, d5, d6;
        logic [5:0]  dbl;   // bit 0 = channel 1
        logic [5:0]  en;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{16'd10,  16'd5,  16'd0,   16'd3, 16'd10,  16'd11, 16'd7,  6'b000000, 6'b111111},
        '{16'd12,  16'd2,  16'd8,   16'd4, 16'd9,   16'd1,  16'd11, 6'b101010, 6'b111111},
        '{16'd9,   16'd3,  16'd6,   16'd9, 16'd1,   16'd4,  16'd2,  6'b000000, 6'b101010},
        '{16'd8,   16'd4,  16'd5,   16'd5, 16'd2,   16'd6,  16'd8,  6'b010100, 6'b111111},
        '{16'd100, 16'd60, 16'd100, 16'd0, 16'd101, 16'd50, 16'd99, 6'b000000, 6'b111111}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] cnt;
    logic          wrap;
    logic          run = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [NCH-1:0] out;
    logic [CW-1:0] period;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    pwm_shadow_top #(.NCH(NCH), .CW(CW)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_i     (cnt),
        .wrap_i    (wrap),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .out_o     (out),
        .period_o  (period)
    );

    // timer core model
    assign wrap = run && (cnt == period);
    always @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (wrap)      cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h (cnt=%0d)", req, act, exp, cnt);
        end
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = AW'(a);
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_wrap();
        do @(negedge clk); while (!wrap);
    endtask

    task automatic wait_cnt(input int v);
        do @(negedge clk); while (cnt != CW'(v));
    endtask

    function automatic logic [5:0] model(input vec_t v, input int c);
        int cm [7];
        logic [5:0] r;
        cm = '{int'(v.per), int'(v.d1), int'(v.d2), int'(v.d3), int'(v.d4), int'(v.d5), int'(v.d6)};
        r = '0;
        for (int n = 1; n <= 6; n++) begin
            logic val;
            if (n >= 2 && v.dbl[n-1]) val = (c >= cm[n-1]) && (c < cm[n]);
            else                      val = (c < cm[n]);
            r[n-1] = v.en[n-1] && val;
        end
        return r;
    endfunction

    function automatic logic [DW-1:0] ctrl_word(input logic [5:0] dbl, input logic [5:0] en);
        logic [DW-1:0] w;
        w = '0;
        for (int n = 2; n <= 6; n++) w[n] = dbl[n-1];
        for (int n = 1; n <= 6; n++) w[8+n] = en[n-1];
        return w;
    endfunction

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 out", 64'(out), 64'd0);
        chk("R1 period", 64'(period), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out after release", 64'(out), 64'd0);
        run = 1'b1;

        // vector table: program, arm all, settle one period, check one period
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            wr(0, v.per); wr(1, v.d1); wr(2, v.d2); wr(3, v.d3);
            wr(4, v.d4); wr(5, v.d5); wr(6, v.d6);
            wr(7, ctrl_word(v.dbl, v.en));
            wr(8, 16'h007f);
            wait_wrap();
            wait_wrap();
            chk("R2 period", 64'(period), 64'(v.per));
            for (int c = 0; c <= int'(v.per); c++) begin
                @(negedge clk);
                chk("R5 R6 R7 vector", 64'(out), 64'(model(v, int'(cnt))));
            end
        end

        // R3: unarmed slot keeps its active value (period 100 in force)
        wr(0, 16'd14);
        wait_wrap();
        wait_wrap();
        @(negedge clk);
        chk("R3 unarmed period kept", 64'(period), 64'd100);

        // R8/R3: arm only slot 1 (bit 1), slot 0 stays
        wr(1, 16'd1);
        wr(8, 16'h0002);
        wait_wrap();
        @(negedge clk);
        chk("R8 partial arm period", 64'(period), 64'd100);
        chk("R3 new duty high at 0", 64'(out[0]), 64'd1);
        @(negedge clk);
        chk("R3 new duty low at 1", 64'(out[0]), 64'd0);

        // R4: arm bit cleared, later write waits
        wr(1, 16'd7);
        wait_wrap();
        wait_wrap();
        wait_cnt(3);
        chk("R4 self-clear duty kept", 64'(out[0]), 64'd0);

        // R7: all disabled -> low
        wr(7, ctrl_word(6'b000000, 6'b000000));
        wait_cnt(3);
        chk("R7 disabled low", 64'(out), 64'd0);
        // R7: enable ch6 in mid-period, in phase (duty 99, count about 5)
        wr(7, ctrl_word(6'b000000, 6'b100000));
        chk("R7 immediate enable", 64'(out), 64'b100000);
        chk("R7 enable cnt", 64'(cnt), 64'd5);

        // R7: bit 1 does not make channel 1 double-edge
        wr(7, ctrl_word(6'b000001, 6'b000001) | 16'h0002);
        wait_cnt(100);
        chk("R7 ch1 single at period", 64'(out[0]), 64'd0);
        @(negedge clk);
        chk("R7 ch1 high at 0", 64'(out[0]), 64'd1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule